// File: doc/BRIEF.md
# Sticky Interrupt Status Register

The block holds eight event flags, one per event source, and keeps each flag set from the moment its event is seen until software reads the register. Each source is an ordinary input line. A per-bit enable vector chooses which sources may latch. A mode input selects how a source is seen: in edge mode only a rising transition counts, and in level mode any cycle in which the source is high counts. A single interrupt request output tells the processor that at least one enabled flag is pending.

A read strobe stands for a register read. During the read cycle the read data shows the flags as they were before the clear. At the next clock edge the flags are cleared, with two exceptions. An event that arrives in the read cycle wins over the clear. In level mode, a source that is still high sets its flag again.

Each bit is a two-state machine with the states IDLE and PEND. The transitions are CAPTURE (IDLE to PEND, when the bit is enabled and its source fires), MASK_OFF (PEND to IDLE, when the enable drops), and READ_CLEAR (PEND to IDLE, when a read comes with no event in the same cycle). A read that comes together with an event leaves the bit in PEND; this is READ_HOLD. The bit positions are fixed: bit 7 transmitter slip, bit 6 output-port slip, bit 5 rate range exceeded, bit 4 left over-range, bit 3 right over-range, bit 2 D-to-E buffer transfer, bit 1 E-to-F buffer transfer, bit 0 receiver error.

Top module: `sticky_irq_status`

## Requirements
- R1: After reset, `rd_data_o` is 0x00 and `irq_o` is 0.
- R2: In edge mode (`level_mode_i`=0), a 0-to-1 change of an enabled source sets its bit, and `rd_data_o` shows it after the next clock edge. A source held high does not set its bit again once a read has cleared it.
- R3: In level mode (`level_mode_i`=1), an enabled source that is high sets its bit. A read while the source is still high leaves the bit set. A read after the source has gone low clears the bit.
- R4: A set bit stays set over any number of cycles without a read while its enable stays 1.
- R5: During a read cycle (`rd_i`=1), `rd_data_o` shows the flags before the clear. Bits with no event in that cycle read 0 after the clock edge.
- R6: An event in the same cycle as a read wins: the bit is set after that clock edge.
- R7: A bit whose enable (`mask_i` bit, 1 = enabled) is 0 never latches and reads 0. Dropping the enable of a set bit clears it at the next clock edge.
- R8: `irq_o` is a register output, active high, and equals the OR of all bits shown on `rd_data_o` in every cycle.
- R9: Source bit k drives only status bit k. The layout is bit 7 transmitter slip, 6 output-port slip, 5 rate range exceeded, 4 left over-range, 3 right over-range, 2 D-to-E transfer, 1 E-to-F transfer, 0 receiver error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 8 | Raw event source lines, one per status bit |
| mask_i | input | 8 | Per-bit enable, 1 lets the bit latch |
| level_mode_i | input | 1 | 0 = edge mode, 1 = level mode |
| rd_i | input | 1 | Register read strobe, one cycle per read |
| rd_data_o | output | 8 | Latched status shown before the clear |
| irq_o | output | 1 | Registered interrupt request, active high |

## Verification
The assertions assume that all inputs are synchronous to `clk` and held stable around the rising edge. `mask_i` and `level_mode_i` may change in any cycle, and a read may come in any cycle, including several cycles in a row. The edge-mode clear check keeps its own registered copy of the sources, so it assumes the sources have a defined value during reset. The bench changes every input only on the falling edge and holds the sources at zero during reset. It mixes directed sequences with random source, enable, mode and read patterns. The reference model is updated on every rising edge and compared on every falling edge.

// File: rtl/sisr_pkg.sv
package sisr_pkg;
    localparam int unsigned SRC_COUNT = 8;

    typedef enum logic {
        BIT_IDLE = 1'b0,
        BIT_PEND = 1'b1
    } bit_state_e;
endpackage

// File: rtl/sisr_event_gen.sv
module sisr_event_gen #(
    parameter int unsigned NBITS = sisr_pkg::SRC_COUNT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] src_i,
    input  logic             level_mode_i,
    output logic [NBITS-1:0] hit_o
);
    logic [NBITS-1:0] src_q;

    // registered copy of the sources for rising-edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
        end else begin
            src_q <= src_i;
        end
    end

    always_comb begin
        if (level_mode_i) begin
            hit_o = src_i;
        end else begin
            hit_o = src_i & ~src_q;
        end
    end
endmodule

// File: rtl/sisr_bit_cell.sv
module sisr_bit_cell
    import sisr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic en_i,
    input  logic rd_i,
    output logic flag_o,
    output logic flag_next_o
);
    bit_state_e state_q;
    bit_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BIT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: CAPTURE, MASK_OFF, READ_CLEAR (READ_HOLD stays in PEND)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BIT_IDLE: begin
                if (en_i && hit_i) begin
                    state_d = BIT_PEND;
                end
            end
            BIT_PEND: begin
                if (!en_i) begin
                    state_d = BIT_IDLE;
                end else if (rd_i && !hit_i) begin
                    state_d = BIT_IDLE;
                end
            end
            default: state_d = BIT_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        flag_o      = (state_q == BIT_PEND);
        flag_next_o = (state_d == BIT_PEND);
    end
endmodule

// File: rtl/sisr_irq_gen.sv
module sisr_irq_gen #(
    parameter int unsigned NBITS = sisr_pkg::SRC_COUNT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] flags_next_i,
    output logic             irq_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= |flags_next_i;
        end
    end
endmodule

// File: rtl/sticky_irq_status.sv
module sticky_irq_status #(
    parameter int unsigned NBITS = sisr_pkg::SRC_COUNT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] src_i,
    input  logic [NBITS-1:0] mask_i,
    input  logic             level_mode_i,
    input  logic             rd_i,
    output logic [NBITS-1:0] rd_data_o,
    output logic             irq_o
);
    logic [NBITS-1:0] hit;
    logic [NBITS-1:0] flags;
    logic [NBITS-1:0] flags_next;

    sisr_event_gen #(.NBITS(NBITS)) u_evt (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_i        (src_i),
        .level_mode_i (level_mode_i),
        .hit_o        (hit)
    );

    for (genvar g = 0; g < NBITS; g++) begin : g_bit
        sisr_bit_cell u_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .hit_i       (hit[g]),
            .en_i        (mask_i[g]),
            .rd_i        (rd_i),
            .flag_o      (flags[g]),
            .flag_next_o (flags_next[g])
        );
    end

    sisr_irq_gen #(.NBITS(NBITS)) u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .flags_next_i (flags_next),
        .irq_o        (irq_o)
    );

    assign rd_data_o = flags;
endmodule

// File: rtl/sticky_irq_status_chk.sv
module sticky_irq_status_chk #(
    parameter int unsigned NBITS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NBITS-1:0] src_i,
    input logic [NBITS-1:0] mask_i,
    input logic             level_mode_i,
    input logic             rd_i,
    input logic [NBITS-1:0] rd_data_o,
    input logic             irq_o
);
    logic [NBITS-1:0] src_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_prev <= '0;
        end else begin
            src_prev <= src_i;
        end
    end

    // R7
    masked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((rd_data_o & ~$past(mask_i)) == '0));

    // R8
    irq_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (|rd_data_o));

    // R4
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> ((rd_data_o & $past(rd_data_o & mask_i)) == $past(rd_data_o & mask_i)));

    // R3
    level_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && level_mode_i) |=> ((rd_data_o & $past(src_i & mask_i)) == $past(src_i & mask_i)));

    // R5
    edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !level_mode_i && ((src_i & ~src_prev) == '0)) |=> (rd_data_o == '0));

    // R6
    read_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !level_mode_i) |=> ((rd_data_o & $past(src_i & ~src_prev & mask_i)) == $past(src_i & ~src_prev & mask_i)));
endmodule

bind sticky_irq_status sticky_irq_status_chk #(.NBITS(NBITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_i        (src_i),
    .mask_i       (mask_i),
    .level_mode_i (level_mode_i),
    .rd_i         (rd_i),
    .rd_data_o    (rd_data_o),
    .irq_o        (irq_o)
);

// File: tb/sim_sticky_irq_status.sv
module sim_sticky_irq_status;
    localparam int CLK_PERIOD = 10;
    localparam int POS_TX_SLIP = 7;
    localparam int POS_RX_ERR  = 0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] src = '0;
    logic [7:0] mask = '0;
    logic       lvl = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] rd_data;
    logic       irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference model state
    logic [7:0] m_stat = '0;
    logic [7:0] m_prev = '0;
    logic       m_irq = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sticky_irq_status u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_i        (src),
        .mask_i       (mask),
        .level_mode_i (lvl),
        .rd_i         (rd),
        .rd_data_o    (rd_data),
        .irq_o        (irq)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_stat = '0;
            m_prev = '0;
            m_irq  = 1'b0;
        end else begin
            for (int i = 0; i < 8; i++) begin
                bit fired;
                fired = lvl ? src[i] : (src[i] && !m_prev[i]);
                if (!mask[i])      m_stat[i] = 1'b0;
                else if (fired)    m_stat[i] = 1'b1;
                else if (rd)       m_stat[i] = 1'b0;
            end
            m_prev = src;
            m_irq  = (m_stat != 0);
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // compare against the model on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R5 model rd_data", rd_data, m_stat);
            chk("R8 model irq", {7'b0, irq}, {7'b0, m_irq});
        end
    end

    task automatic step(input logic [7:0] s, input logic [7:0] m, input logic l, input logic r);
        src = s; mask = m; lvl = l; rd = r;
        @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset data", rd_data, 8'h00);
        chk("R1 reset irq", {7'b0, irq}, 8'h00);

        step(8'h01, 8'hff, 0, 0);
        chk("R2 edge capture", rd_data, 8'h01);
        chk("R8 irq set", {7'b0, irq}, 8'h01);
        step(8'h01, 8'hff, 0, 0);
        step(8'h01, 8'hff, 0, 0);
        chk("R4 sticky hold", rd_data, 8'h01);

        src = 8'h01; rd = 1'b1;
        #1 chk("R5 pre-clear read", rd_data, 8'h01);
        @(negedge clk);
        chk("R2 held source no relatch", rd_data, 8'h00);
        chk("R8 irq clear", {7'b0, irq}, 8'h00);

        step(8'h80, 8'hff, 0, 1);
        chk("R6 event wins over read", rd_data, 8'h80);
        step(8'h00, 8'hff, 0, 1);
        chk("R5 read clears", rd_data, 8'h00);

        step(8'h04, 8'hff, 1, 0);
        chk("R3 level capture", rd_data, 8'h04);
        step(8'h04, 8'hff, 1, 1);
        chk("R3 level read keeps", rd_data, 8'h04);
        step(8'h00, 8'hff, 1, 1);
        chk("R3 level read clears after drop", rd_data, 8'h00);

        step(8'h02, 8'hfd, 0, 0);
        chk("R7 masked never latches", rd_data, 8'h00);
        step(8'h0a, 8'hfd, 0, 0);
        chk("R7 unmasked latches", rd_data, 8'h08);
        step(8'h0a, 8'hf5, 0, 0);
        chk("R7 mask off clears", rd_data, 8'h00);
        step(8'h00, 8'hff, 0, 1);

        for (int k = 0; k < 8; k++) begin
            step(8'(1 << k), 8'hff, 0, 0);
            chk("R9 bit independence", rd_data, 8'(1 << k));
            step(8'h00, 8'hff, 0, 1);
            chk("R9 cleared", rd_data, 8'h00);
        end
        step(8'(1 << POS_TX_SLIP), 8'hff, 0, 0);
        chk("R9 transmitter slip at bit 7", rd_data, 8'h80);
        step(8'(1 << POS_RX_ERR), 8'hff, 0, 1);
        chk("R9 receiver error at bit 0", rd_data, 8'h01);
        step(8'h00, 8'hff, 0, 1);

        for (int n = 0; n < 2000; n++) begin
            logic [7:0] s;
            logic [7:0] m;
            s = 8'($urandom);
            m = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'hff;
            step(s, m, (n / 200) % 2 == 1, $urandom_range(0, 3) == 0);
        end

        finish_run();
    end
endmodule